// File: doc/BRIEF.md
# Synchronized-Update Register Bank for Four Current DACs

This block is the register bank for a group of current-output DAC channels. A bus master writes each channel's 16-bit code and its control byte through a plain synchronous register port. For every channel the bank keeps two copies of the code. The shadow code is the value last written. The active code is the one that drives the converter.

The active code of channel n is frozen only while the update-hold bit for n is set in the data register of every channel. Software therefore sets bit n in all four data registers, writes the new codes, and then clears bit n in any one register. That releases every held channel on the same clock edge.

A clear bit in each control register zeroes the channel's data and blocks writes to it. The other control fields (power-down, pull-down, bandwidth code and over-temperature shutdown enable) go straight to output pins. The register port is a direct load/store path with no transfer handshake: a write completes on the edge where it is presented, and read data is combinational from the address.

Top module: `dac_sync_regbank`

## Requirements
- R1: A data-register write stores wdata[27:12] as the channel's 16-bit shadow code. The high part is bits [27:17] and the low part is bits [16:12]. A read of the data register returns the shadow code in the same positions.
- R2: In a data register, bits [31:28] and [11:4] read as zero whatever was written to them.
- R3: Data-register bits [3:0] hold hold-bits H3..H0. Bit n belongs to channel n, whichever channel's register it sits in. The stored bits read back at [3:0].
- R4: While bit n is 1 in all four data registers, channel n's active code does not change, even when its shadow code is rewritten.
- R5: If bit n was 0 in at least one data register before a write edge, then a write to channel n's data updates its active code on that same edge. While the channel is not held, the active code keeps tracking the shadow code.
- R6: When an edge clears the last set copy of bit n, the held shadow code of channel n reaches the active code on the following edge.
- R7: While control bit 7 of a channel is 0, its shadow code, its hold bits and its active code are zero and data writes to it are ignored. A control write that makes bit 7 zero clears all three on that same edge, whatever the hold state.
- R8: The control bits map to outputs as follows: bit 0 is power-down, bit 1 is pull-down, bits [5:2] are the bandwidth code and bit 6 is the over-temperature shutdown enable. Each output follows a control write on its edge, and the control register reads back all 8 bits.
- R9: After reset, every data register is 0 and every control register is 0x01. All channels come up powered down, with codes at zero and data writes blocked.
- R10: Channel n's data register is at byte address 8n and its control register at 8n+4. Address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 5 | Byte address of the register |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| dac_code | output | 64 | Active codes, channel n at [16n+15:16n] |
| dac_pd | output | 4 | Power-down per channel |
| dac_pulldown | output | 4 | Pull-down enable per channel |
| dac_ot_shdn_en | output | 4 | Over-temperature shutdown enable per channel |
| dac_bw | output | 16 | Bandwidth code, channel n at [4n+3:4n] |

## Verification
A write presented before edge T shows its effect at the register outputs, in the shadow read-back and, for an unheld channel, in the active code immediately after T. A hold release written at edge T moves the held code only after edge T+1. A clear is visible right after the control-write edge. The bench drives every input at a falling edge and samples every output at the next falling edge, one full rising edge later. Read data is combinational, so it is sampled shortly after the address settles without a clock. The bench model advances one step per rising edge, using the hold state from before that edge, so each expected value lines up with the cycle in which it is due.

// File: rtl/dac_bank_pkg.sv
package dac_bank_pkg;
  localparam int CODE_W   = 16;
  localparam int CODE_LSB = 12;
  localparam int CTRL_W   = 8;
  localparam int BW_W     = 4;
  localparam int DATA_W   = 32;

  typedef struct packed {
    logic            wr_ena;   // bit 7: 0 clears and blocks data writes
    logic            ot_en;    // bit 6
    logic [BW_W-1:0] bw;       // bits 5:2
    logic            pull;     // bit 1
    logic            pd;       // bit 0
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{wr_ena: 1'b0, ot_en: 1'b0, bw: '0, pull: 1'b0, pd: 1'b1};

  function automatic logic [CODE_W-1:0] code_of(input logic [DATA_W-1:0] w);
    return w[CODE_LSB+CODE_W-1:CODE_LSB];
  endfunction
endpackage

// File: rtl/dac_addr_decode.sv
module dac_addr_decode #(
  parameter int NCH    = 4,
  parameter int ADDR_W = $clog2(NCH) + 3
) (
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   we,
  output logic [NCH-1:0]         data_we,
  output logic [NCH-1:0]         ctrl_we,
  output logic [$clog2(NCH)-1:0] idx,
  output logic                   is_ctrl
);
  localparam int IDX_W = $clog2(NCH);

  assign idx     = addr[ADDR_W-1:3];
  assign is_ctrl = addr[2];

  for (genvar k = 0; k < NCH; k++) begin : g_dec
    assign data_we[k] = we && !is_ctrl && (idx == IDX_W'(k));
    assign ctrl_we[k] = we &&  is_ctrl && (idx == IDX_W'(k));
  end
endmodule

// File: rtl/dac_sync_combine.sv
module dac_sync_combine #(
  parameter int NCH = 4
) (
  input  logic [NCH*NCH-1:0] sync_flat,   // register k occupies [k*NCH +: NCH]
  output logic [NCH-1:0]     hold
);
  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic [NCH-1:0] column;
    for (genvar k = 0; k < NCH; k++) begin : g_reg
      assign column[k] = sync_flat[k*NCH + n];
    end
    assign hold[n] = &column;
  end
endmodule

// File: rtl/dac_chan_regs.sv
module dac_chan_regs
  import dac_bank_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_we,
  input  logic              ctrl_we,
  input  logic [CODE_W-1:0] wr_code,
  input  logic [NCH-1:0]    wr_sync,
  input  logic [CTRL_W-1:0] wr_ctrl,
  input  logic              hold_i,
  output ctrl_t             ctrl_q,
  output logic [CODE_W-1:0] shadow_q,
  output logic [NCH-1:0]    sync_q,
  output logic [CODE_W-1:0] active_q
);
  ctrl_t             ctrl_d;
  logic              clear_now;
  logic [CODE_W-1:0] shadow_d, active_d;
  logic [NCH-1:0]    sync_d;

  always_comb begin
    ctrl_d    = ctrl_we ? ctrl_t'(wr_ctrl) : ctrl_q;
    clear_now = !ctrl_d.wr_ena;
    shadow_d  = shadow_q;
    sync_d    = sync_q;
    if (data_we && ctrl_q.wr_ena) begin
      shadow_d = wr_code;
      sync_d   = wr_sync;
    end
    if (clear_now) begin
      shadow_d = '0;
      sync_d   = '0;
    end
    // hold_i reflects stored bits before this edge
    active_d = clear_now ? '0 : (hold_i ? active_q : shadow_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= CTRL_RST;
      shadow_q <= '0;
      sync_q   <= '0;
      active_q <= '0;
    end else begin
      ctrl_q   <= ctrl_d;
      shadow_q <= shadow_d;
      sync_q   <= sync_d;
      active_q <= active_d;
    end
  end

  // R4: a held, uncleared channel keeps its active code
  a_r4_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && !clear_now) |=> $stable(active_q));
  // R5: an unheld channel presents its shadow code after the edge
  a_r5_follow_shadow: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_i && !clear_now) |=> (active_q == shadow_q));
  // R7: clear zeroes every stored copy at once
  a_r7_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    clear_now |=> (active_q == '0 && shadow_q == '0 && sync_q == '0));
  // R7: data writes to a disabled channel leave nothing behind
  a_r7_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !ctrl_q.wr_ena) |=> (shadow_q == '0));
endmodule

// File: rtl/dac_sync_regbank.sv
module dac_sync_regbank
  import dac_bank_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = $clog2(NCH) + 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic                   reg_we,
  input  logic [DATA_W-1:0]      reg_wdata,
  output logic [DATA_W-1:0]      reg_rdata,
  output logic [NCH*CODE_W-1:0]  dac_code,
  output logic [NCH-1:0]         dac_pd,
  output logic [NCH-1:0]         dac_pulldown,
  output logic [NCH-1:0]         dac_ot_shdn_en,
  output logic [NCH*BW_W-1:0]    dac_bw
);
  localparam int IDX_W = $clog2(NCH);

  logic [NCH-1:0]     data_we, ctrl_we, hold;
  logic [IDX_W-1:0]   rd_idx;
  logic               rd_ctrl;
  logic [NCH*NCH-1:0] sync_flat;
  ctrl_t              ctrl_q   [NCH];
  logic [CODE_W-1:0]  shadow_q [NCH];
  logic [CODE_W-1:0]  active_q [NCH];
  logic [NCH-1:0]     sync_q   [NCH];
  logic               unused_bits;

  assign unused_bits = ^{reg_wdata[31:28], reg_wdata[11:8], reg_addr[1:0]};

  dac_addr_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
    .addr(reg_addr), .we(reg_we), .data_we(data_we), .ctrl_we(ctrl_we),
    .idx(rd_idx), .is_ctrl(rd_ctrl)
  );

  dac_sync_combine #(.NCH(NCH)) u_hold (.sync_flat(sync_flat), .hold(hold));

  for (genvar k = 0; k < NCH; k++) begin : g_chan
    dac_chan_regs #(.NCH(NCH)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .data_we(data_we[k]), .ctrl_we(ctrl_we[k]),
      .wr_code(code_of(reg_wdata)), .wr_sync(reg_wdata[NCH-1:0]),
      .wr_ctrl(reg_wdata[CTRL_W-1:0]), .hold_i(hold[k]),
      .ctrl_q(ctrl_q[k]), .shadow_q(shadow_q[k]), .sync_q(sync_q[k]),
      .active_q(active_q[k])
    );
    assign sync_flat[k*NCH +: NCH]       = sync_q[k];
    assign dac_code[k*CODE_W +: CODE_W]  = active_q[k];
    assign dac_pd[k]                     = ctrl_q[k].pd;
    assign dac_pulldown[k]               = ctrl_q[k].pull;
    assign dac_ot_shdn_en[k]             = ctrl_q[k].ot_en;
    assign dac_bw[k*BW_W +: BW_W]        = ctrl_q[k].bw;
  end

  always_comb begin
    if (rd_ctrl) reg_rdata = DATA_W'(ctrl_q[rd_idx]);
    else         reg_rdata = (DATA_W'(shadow_q[rd_idx]) << CODE_LSB) | DATA_W'(sync_q[rd_idx]);
  end

  // R2: reserved data fields never read back nonzero
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ctrl |-> (reg_rdata[31:28] == 4'h0 && reg_rdata[11:8] == 4'h0));
endmodule

// File: tb/dac_sync_regbank_tb.sv
module dac_sync_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] dac_code;
  logic [3:0]  dac_pd, dac_pulldown, dac_ot_shdn_en;
  logic [15:0] dac_bw;

  int checks = 0, errors = 0;
  logic [15:0] m_sh [4];
  logic [15:0] m_ac [4];
  logic [3:0]  m_sy [4];
  logic [7:0]  m_ct [4];
  logic [3:0]  m_hold;

  always #10 clk = ~clk;

  dac_sync_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dac_code(dac_code),
    .dac_pd(dac_pd), .dac_pulldown(dac_pulldown),
    .dac_ot_shdn_en(dac_ot_shdn_en), .dac_bw(dac_bw)
  );

  function automatic logic [31:0] dword(input logic [15:0] code, input logic [3:0] sy);
    return {4'h0, code, 8'h00, sy};
  endfunction

  task automatic check(input string req, input logic ok, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // bench model, one step per rising edge; hold taken from pre-edge state
  task automatic model_step(input logic we, input logic [4:0] a, input logic [31:0] wd);
    int k;
    for (int n = 0; n < 4; n++)
      m_hold[n] = m_sy[0][n] & m_sy[1][n] & m_sy[2][n] & m_sy[3][n];
    k = int'(a[4:3]);
    if (we) begin
      if (a[2]) m_ct[k] = wd[7:0];
      else if (m_ct[k][7]) begin m_sh[k] = wd[27:12]; m_sy[k] = wd[3:0]; end
    end
    for (int c = 0; c < 4; c++) begin
      if (!m_ct[c][7]) begin m_sh[c] = '0; m_sy[c] = '0; m_ac[c] = '0; end
      else if (!m_hold[c]) m_ac[c] = m_sh[c];
    end
  endtask

  task automatic compare_model();
    for (int c = 0; c < 4; c++) begin
      check(m_hold[c] ? "R4" : "R5", dac_code[c*16 +: 16] === m_ac[c],
            32'(dac_code[c*16 +: 16]), 32'(m_ac[c]));
      check("R8", {dac_ot_shdn_en[c], dac_bw[c*4 +: 4], dac_pulldown[c], dac_pd[c]} === m_ct[c][6:0],
            32'({dac_ot_shdn_en[c], dac_bw[c*4 +: 4], dac_pulldown[c], dac_pd[c]}), 32'(m_ct[c][6:0]));
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic tick(input logic we, input logic [4:0] a, input logic [31:0] wd);
    reg_we = we; reg_addr = a; reg_wdata = wd;
    @(posedge clk);
    model_step(we, a, wd);
    @(negedge clk);
    reg_we = 1'b0;
    compare_model();
  endtask

  task automatic rd(input string req, input logic [4:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    check(req, reg_rdata === exp, reg_rdata, exp);
  endtask

  task automatic code_is(input string req, input int c, input logic [15:0] exp);
    check(req, dac_code[c*16 +: 16] === exp, 32'(dac_code[c*16 +: 16]), 32'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic        we;
    logic [4:0]  a;
    logic [31:0] wd;
    void'($urandom(32'd20240611));
    for (int c = 0; c < 4; c++) begin
      m_sh[c] = '0; m_ac[c] = '0; m_sy[c] = '0; m_ct[c] = 8'h01;
    end
    m_hold = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    check("R9", dac_code === 64'h0, 32'(dac_code[31:0]), 32'h0);
    check("R9", dac_pd === 4'hF, 32'(dac_pd), 32'hF);
    rd("R9", 5'h0C, 32'h01);
    rd("R9", 5'h10, 32'h0);

    // R7 data write blocked while bit 7 is 0
    tick(1'b1, 5'h00, dword(16'h1234, 4'h0));
    code_is("R7", 0, 16'h0);
    rd("R7", 5'h00, 32'h0);

    // enable all channels (R8 power-up)
    for (int c = 0; c < 4; c++) tick(1'b1, 5'(c*8 + 4), 32'h80);
    check("R8", dac_pd === 4'h0, 32'(dac_pd), 32'h0);
    rd("R8", 5'h0C, 32'h80);

    // R5 immediate update; R1/R2 read-back with reserved bits written as ones
    tick(1'b1, 5'h08, 32'hF000_0F00 | dword(16'hABCD, 4'h0));
    code_is("R5", 1, 16'hABCD);
    rd("R1", 5'h08, 32'h0ABC_D000);
    rd("R2", 5'h08, 32'h0ABC_D000);

    // R3/R4 set hold bit 2 in all four registers
    for (int c = 0; c < 4; c++) tick(1'b1, 5'(c*8), dword(16'h1000 + 16'(c), 4'h4));
    rd("R3", 5'h18, dword(16'h1003, 4'h4));
    tick(1'b1, 5'h10, dword(16'h7777, 4'h4));
    code_is("R4", 2, 16'h1002);
    rd("R1", 5'h10, dword(16'h7777, 4'h4));
    tick(1'b0, 5'h0, 32'h0);
    code_is("R4", 2, 16'h1002);

    // R6 release by a different channel's register
    tick(1'b1, 5'h00, dword(16'h1000, 4'h0));
    code_is("R6", 2, 16'h1002);
    tick(1'b0, 5'h0, 32'h0);
    code_is("R6", 2, 16'h7777);

    // R7 clear while a write is held
    tick(1'b1, 5'h00, dword(16'h1000, 4'h4));
    tick(1'b1, 5'h10, dword(16'h5555, 4'h4));
    code_is("R4", 2, 16'h7777);
    tick(1'b1, 5'h14, 32'h00);
    code_is("R7", 2, 16'h0);
    rd("R7", 5'h10, 32'h0);
    tick(1'b1, 5'h10, dword(16'h2222, 4'h4));
    rd("R7", 5'h10, 32'h0);
    tick(1'b1, 5'h14, 32'h80);

    // R10 address low bits ignored
    tick(1'b1, 5'h1B, dword(16'h0F0F, 4'h0));
    code_is("R10", 3, 16'h0F0F);
    rd("R10", 5'h19, dword(16'h0F0F, 4'h0));

    // R8 control fields
    tick(1'b1, 5'h0E, 32'hEB);
    check("R8", dac_pd[1] && dac_pulldown[1] && dac_ot_shdn_en[1] && dac_bw[7:4] == 4'hA,
          32'({dac_ot_shdn_en[1], dac_bw[7:4], dac_pulldown[1], dac_pd[1]}), 32'h6B);
    rd("R8", 5'h0C, 32'hEB);

    // random traffic biased toward holds
    for (int i = 0; i < 800; i++) begin
      we = ($urandom % 4) != 0;
      a  = 5'($urandom);
      wd = $urandom;
      for (int b = 0; b < 4; b++) wd[b] = ($urandom % 4) != 0;
      if (a[2]) wd[7] = ($urandom % 8) != 0;
      tick(we, a, wd);
      if (i % 16 == 0) begin
        int c = int'(a[4:3]);
        rd("R1", 5'(c*8), dword(m_sh[c], m_sy[c]));
        rd("R8", 5'(c*8 + 4), 32'(m_ct[c]));
      end
    end
    finish_run();
  end
endmodule